// File: doc/BRIEF.md
# Configurable Interrupt Routing Controller

This block gathers 32 level-sensitive interrupt requests and steers each of them onto at most one of 15 interrupt output lines. Software controls the steering through a small window of 32-bit registers: a global enable mask, a read-only view of the raw request levels, and four routing registers that hold a 4-bit destination field for every request.

An output line is raised while at least one request is active, enabled in the mask, and routed to that line. Alongside the output lines, the block exports the set of pending requests for each output, so a handler can see at once which sources it owns. It also exports the index of the highest-numbered active output with a valid flag. A higher output index means a higher priority, because the low outputs are normally wired to processor interrupt lines in ascending order.

Top module: `irq_router`

## Requirements
- R1: After a synchronous reset the mask register, all routing registers, `irq_out`, `bus_rdata` and `top_valid` are zero, so every request starts masked and disconnected.
- R2: Each request passes through a two-flop synchronizer, and the status register at byte offset 0x04 shows the synchronized levels, two clock edges after `irq_in` changes.
- R3: The mask register at byte offset 0x00 is readable and writable as a full 32-bit word, and bit n enables request n.
- R4: A routing field of 0 disconnects its request, and a field value v from 1 to 15 sends the request to output v-1 only. A request therefore drives no more than one output.
- R5: Routing registers sit at byte offsets 0x08, 0x0C, 0x10 and 0x14 (register indices 0 to 3). The field of request n is bits [4*(n mod 8)+3 : 4*(n mod 8)] of routing register 3 - n/8, so requests 24 to 31 live at 0x08 and requests 0 to 7 live at 0x14.
- R6: `irq_out[o]` is a register that holds the OR of the pending set of output o. It rises one edge after the status register first shows a routed, unmasked active request, which is three edges after the input changes.
- R7: Outputs are level-based. An output stays high while any routed, unmasked request stays active, and it falls once the request drops, is masked or is re-routed.
- R8: Bus writes to the status register, to misaligned offsets or to offsets at or beyond 0x18 change no register. Reads of any such unmapped offset return zero.
- R9: `top_valid` is high exactly when some output is high, and `top_idx` then gives the highest set output index. With no output high, both are zero.
- R10: `out_pending[o*32 +: 32]` equals mask AND status AND the set of requests whose field selects output o. It follows the registers in the same cycle.
- R11: Every routing register reads back in full. A read-modify-write of one 4-bit field leaves the other seven fields of that register unchanged.
- R12: A read strobe latches the addressed value into `bus_rdata` at the next edge, using the register contents from before any write in the same cycle. `bus_rdata` holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level interrupt requests, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset into the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 15 | Registered interrupt output lines |
| out_pending | output | 480 | Pending routed requests for each output, 32 bits per output |
| top_idx | output | 4 | Highest active output index |
| top_valid | output | 1 | Some output is active |

## Verification
A request change reaches the status register after two edges and `irq_out` after three. A register write takes effect at the next edge, so `out_pending` moves straight away and `irq_out` moves one edge later. Read data appears after the edge that samples the strobe. The bench drives inputs just after the falling edge and compares at every falling edge against a behavioural model. That model advances its synchronizer, status, output and read-data state once per rising edge, so each result is checked in the cycle it is due. The directed checks on output timing sample the cycle before the output rises as well as the cycle it rises.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int IRQ_INPUTS  = 32;
  localparam int IRQ_OUTPUTS = 15;
  localparam int SEL_W       = 4;
  localparam int WORD_W      = 32;
  localparam int ROUTE_REGS  = IRQ_INPUTS * SEL_W / WORD_W;
  localparam int FIELDS_PER_REG = WORD_W / SEL_W;

  localparam int OFF_MASK   = 'h00;
  localparam int OFF_STATUS = 'h04;
  localparam int OFF_ROUTE0 = 'h08;
endpackage

// File: rtl/irq_route_sync.sv
module irq_route_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_router_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int SW     = 4,
  parameter int DW     = 32,
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DW-1:0]      wdata,
  input  logic [N_IN-1:0]    status,
  output logic [DW-1:0]      rdata,
  output logic [N_IN-1:0]    mask,
  output logic [N_IN*SW-1:0] fields
);
  localparam int NREG = N_IN * SW / DW;
  localparam int FPR  = DW / SW;

  logic [NREG-1:0][DW-1:0] route_q;
  logic [N_IN-1:0]         mask_q;
  logic [DW-1:0]           rdata_q;
  logic [DW-1:0]           rd_mux;
  logic                    hit_mask;
  logic                    hit_stat;
  logic [NREG-1:0]         hit_route;

  assign hit_mask = (addr == ADDR_W'(OFF_MASK));
  assign hit_stat = (addr == ADDR_W'(OFF_STATUS));

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_dec
      assign hit_route[r] = (addr == ADDR_W'(OFF_ROUTE0 + 4 * r));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      route_q <= '0;
    end else if (wr_en) begin
      if (hit_mask) mask_q <= wdata[N_IN-1:0];
      for (int k = 0; k < NREG; k++) begin
        if (hit_route[k]) route_q[k] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_mask) rd_mux[N_IN-1:0] = mask_q;
    if (hit_stat) rd_mux[N_IN-1:0] = status;
    for (int k = 0; k < NREG; k++) begin
      if (hit_route[k]) rd_mux = route_q[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  genvar n;
  generate
    for (n = 0; n < N_IN; n++) begin : g_fld
      assign fields[n*SW +: SW] = route_q[NREG-1-(n/FPR)][(n%FPR)*SW +: SW];
    end
  endgenerate

  assign rdata = rdata_q;
  assign mask  = mask_q;
endmodule

// File: rtl/irq_route_core.sv
module irq_route_core #(
  parameter int N_IN  = 32,
  parameter int N_OUT = 15,
  parameter int SW    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IN-1:0]       mask,
  input  logic [N_IN-1:0]       status,
  input  logic [N_IN*SW-1:0]    fields,
  output logic [N_OUT*N_IN-1:0] pending,
  output logic [N_OUT-1:0]      irq_out
);
  logic [N_IN-1:0]             live;
  logic [N_OUT-1:0][N_IN-1:0]  member;
  logic [N_OUT-1:0]            any;
  logic [N_OUT-1:0]            out_q;

  assign live = mask & status;

  genvar o, n;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_out
      for (n = 0; n < N_IN; n++) begin : g_in
        assign member[o][n] = (fields[n*SW +: SW] == SW'(o + 1));
      end
      assign pending[o*N_IN +: N_IN] = live & member[o];
      assign any[o] = |(live & member[o]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) out_q <= '0;
    else     out_q <= any;
  end

  assign irq_out = out_q;
endmodule

// File: rtl/irq_route_prio.sv
module irq_route_prio #(
  parameter int N_OUT = 15,
  parameter int IDX_W = 4
) (
  input  logic [N_OUT-1:0] vec,
  output logic [IDX_W-1:0] idx,
  output logic             valid
);
  always_comb begin
    idx   = '0;
    valid = 1'b0;
    for (int o = 0; o < N_OUT; o++) begin
      if (vec[o]) begin
        idx   = IDX_W'(o);
        valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int N_IN        = IRQ_INPUTS,
  parameter int N_OUT       = IRQ_OUTPUTS,
  parameter int SW          = SEL_W,
  parameter int DW          = WORD_W,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int IDX_W       = $clog2(N_OUT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_IN-1:0]       irq_in,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DW-1:0]         bus_wdata,
  output logic [DW-1:0]         bus_rdata,
  output logic [N_OUT-1:0]      irq_out,
  output logic [N_OUT*N_IN-1:0] out_pending,
  output logic [IDX_W-1:0]      top_idx,
  output logic                  top_valid
);
  logic [N_IN-1:0]    status_q;
  logic [N_IN-1:0]    mask_q;
  logic [N_IN*SW-1:0] fields;

  irq_route_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(irq_in), .q(status_q)
  );

  irq_route_regs #(.N_IN(N_IN), .SW(SW), .DW(DW), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status_q), .rdata(bus_rdata),
    .mask(mask_q), .fields(fields)
  );

  irq_route_core #(.N_IN(N_IN), .N_OUT(N_OUT), .SW(SW)) u_core (
    .clk(clk), .rst(rst), .mask(mask_q), .status(status_q), .fields(fields),
    .pending(out_pending), .irq_out(irq_out)
  );

  irq_route_prio #(.N_OUT(N_OUT), .IDX_W(IDX_W)) u_prio (
    .vec(irq_out), .idx(top_idx), .valid(top_valid)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int N_IN   = 32,
  parameter int N_OUT  = 15,
  parameter int IDX_W  = 4,
  parameter int ADDR_W = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic [N_OUT-1:0]      irq_out,
  input logic [IDX_W-1:0]      top_idx,
  input logic                  top_valid,
  input logic [N_OUT*N_IN-1:0] out_pending,
  input logic [N_IN-1:0]       mask_q,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: outputs are cleared by the reset edge
  always @(negedge clk) begin
    if (rst_d) a_reset_clear_r1: assert (irq_out == '0 && !top_valid);
  end

  p_top_points_r9: assert property (@(posedge clk) disable iff (rst)
    top_valid |-> ((irq_out >> top_idx) == N_OUT'(1)));

  p_none_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !top_valid |-> (irq_out == '0 && top_idx == '0));

  p_stat_write_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(4)) |=> $stable(mask_q));

  genvar o, n;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_o
      p_out_needs_pending_r6: assert property (@(posedge clk) disable iff (rst)
        irq_out[o] |-> $past(|out_pending[o*N_IN +: N_IN]));
    end
    for (n = 0; n < N_IN; n++) begin : g_n
      logic [N_OUT-1:0] col;
      for (o = 0; o < N_OUT; o++) begin : g_c
        assign col[o] = out_pending[o*N_IN + n];
      end
      p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(col));
    end
  endgenerate
endmodule

bind irq_router irq_router_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .irq_out(irq_out), .top_idx(top_idx),
  .top_valid(top_valid), .out_pending(out_pending), .mask_q(mask_q),
  .bus_wr(bus_wr), .bus_addr(bus_addr)
);

// File: tb/tb_irq_router.sv
`timescale 1ns/1ps
module tb_irq_router;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  irq_in = '0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [14:0]  irq_out;
  logic [479:0] out_pending;
  logic [3:0]   top_idx;
  logic         top_valid;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irq_router dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .out_pending(out_pending), .top_idx(top_idx),
    .top_valid(top_valid)
  );

  // behavioural reference state
  logic [31:0] mask_m, s1_m, st_m, rdat_m;
  logic [31:0] rt_m [4];
  logic [14:0] out_m;

  function automatic int fld(int n);
    return int'((rt_m[3 - n / 8] >> (4 * (n % 8))) & 32'hF);
  endfunction

  function automatic logic [31:0] pend(int o);
    logic [31:0] p = '0;
    for (int n = 0; n < 32; n++)
      if (mask_m[n] && st_m[n] && fld(n) == o + 1) p[n] = 1'b1;
    return p;
  endfunction

  function automatic logic [31:0] rdval(logic [7:0] a);
    case (a)
      8'h00: return mask_m;
      8'h04: return st_m;
      8'h08: return rt_m[0];
      8'h0C: return rt_m[1];
      8'h10: return rt_m[2];
      8'h14: return rt_m[3];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mask_m = '0; s1_m = '0; st_m = '0; rdat_m = '0; out_m = '0;
      for (int k = 0; k < 4; k++) rt_m[k] = '0;
    end else begin
      logic [14:0] nxt;
      if (bus_rd) rdat_m = rdval(bus_addr);
      for (int o = 0; o < 15; o++) nxt[o] = |pend(o);
      out_m = nxt;
      st_m  = s1_m;
      s1_m  = irq_in;
      if (bus_wr) begin
        case (bus_addr)
          8'h00: mask_m = bus_wdata;
          8'h08: rt_m[0] = bus_wdata;
          8'h0C: rt_m[1] = bus_wdata;
          8'h10: rt_m[2] = bus_wdata;
          8'h14: rt_m[3] = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      int ti;
      ti = 0;
      for (int o = 0; o < 15; o++) if (out_m[o]) ti = o;
      chk("R6 irq_out", {17'h0, irq_out}, {17'h0, out_m});
      chk("R12 bus_rdata", bus_rdata, rdat_m);
      chk("R9 top_valid", {31'h0, top_valid}, {31'h0, |out_m});
      chk("R9 top_idx", {28'h0, top_idx}, 32'(ti));
      for (int o = 0; o < 15; o++)
        chk("R10 out_pending", out_pending[o*32 +: 32], pend(o));
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    cyc();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R1 reset state
    chk("R1 irq_out", {17'h0, irq_out}, 32'h0);
    chk("R1 top_valid", {31'h0, top_valid}, 32'h0);
    rd(8'h00, v); chk("R1 mask", v, 32'h0);
    rd(8'h08, v); chk("R1 route0", v, 32'h0);
    rd(8'h14, v); chk("R1 route3", v, 32'h0);

    // R3 mask read/write
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R3 mask", v, 32'hFFFF_FFFF);

    // R5 request 19 to output 3: register 1 (0x0C), bits 15:12, value 4
    wr(8'h0C, 32'h0000_4000);
    rd(8'h0C, v); chk("R5 route1", v, 32'h0000_4000);

    // R6 timing: input change then three edges to the output
    irq_in[19] = 1'b1;
    cyc(); chk("R6 edge1", {17'h0, irq_out}, 32'h0);
    cyc(); chk("R6 edge2", {17'h0, irq_out}, 32'h0);
    chk("R10 pending3", out_pending[3*32 +: 32], 32'h0008_0000);
    cyc(); chk("R6 edge3", {17'h0, irq_out}, 32'h0000_0008);
    chk("R9 idx3", {28'h0, top_idx}, 32'd3);
    rd(8'h04, v); chk("R2 status", v, 32'h0008_0000);

    // R9 request 2 to output 14: register 3 (0x14), bits 11:8, value 15
    wr(8'h14, 32'h0000_0F00);
    irq_in[2] = 1'b1;
    repeat (3) cyc();
    chk("R9 idx14", {28'h0, top_idx}, 32'd14);
    chk("R4 two outs", {17'h0, irq_out}, 32'h0000_4008);

    // R11 read-modify-write of the field of request 1
    rd(8'h14, v);
    wr(8'h14, (v & ~32'h0000_00F0) | 32'h0000_0010);
    rd(8'h14, v); chk("R11 rmw", v, 32'h0000_0F10);
    cyc(); chk("R11 out14 kept", {31'h0, irq_out[14]}, 32'h1);

    // R4 disconnect request 19 with field 0
    wr(8'h0C, 32'h0);
    cyc(); chk("R4 disconnect", {31'h0, irq_out[3]}, 32'h0);

    // R7 masking and dropping
    wr(8'h00, 32'hFFFF_FFFB);
    cyc(); chk("R7 masked", {17'h0, irq_out}, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    cyc(); chk("R7 unmasked", {31'h0, irq_out[14]}, 32'h1);
    irq_in[2] = 1'b0;
    repeat (3) cyc();
    chk("R7 dropped", {17'h0, irq_out}, 32'h0);

    // R8 ignored writes and unmapped reads
    wr(8'h04, 32'h0);
    wr(8'h40, 32'h0);
    wr(8'h01, 32'h0);
    rd(8'h00, v); chk("R8 mask kept", v, 32'hFFFF_FFFF);
    rd(8'h14, v); chk("R8 route kept", v, 32'h0000_0F10);
    rd(8'h18, v); chk("R8 unmapped 18", v, 32'h0);
    rd(8'h40, v); chk("R8 unmapped 40", v, 32'h0);

    // random phase compared every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] addrs [9];
      addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h40, 8'h02};
      if ($urandom_range(0, 3) == 0) irq_in = $urandom;
      bus_addr  = addrs[$urandom_range(0, 8)];
      bus_wdata = $urandom;
      bus_wr    = ($urandom_range(0, 5) == 0);
      bus_rd    = ($urandom_range(0, 2) == 0);
      cyc();
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    cyc();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule